// File: doc/BRIEF.md
# Serial Memory Link Bring-Up Sequencer

This block is the host-side controller that brings a multi-lane serial memory link from reset into normal traffic. Once the system reset is released, it asks an external agent to load the memory device's configuration registers. It keeps the device in reset, with the host transmitter in high impedance, until that load is acknowledged. It then releases the device reset and steps the transmitter through a fixed series of training patterns. Each step waits for a receive-side milestone reported by the PHY and descrambler: clock alignment on every lane, descrambler lock on every lane, non-zero data, training-sequence detection, word lock with lane alignment, and finally the device's return to scrambled null while its return-token indication is active.

The current step is a registered one-hot status byte. Every wait step has a programmable timeout. When a timeout expires, the block latches a sticky error and restarts from the reset step, which includes a fresh register-load request. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `link_init_seq`

## Requirements
- R1: `status` always has exactly one bit set, with these codes: reset 0x01, clock align 0x02, descrambler sync 0x04, non-zero wait 0x08, training-sequence sync 0x10, lane deskew 0x20, zero wait 0x40, active 0x80.
- R2: One clock after `rst_n` rises, `regload_req` goes to 1 while `dev_rst_n` stays 0. A `regload_done` that arrives while `regload_req` is 0 is ignored. On the first edge where both are 1, `dev_rst_n` goes to 1, `regload_req` goes to 0 and `status` becomes 0x02.
- R3: `tx_hiz` is 1 exactly while `dev_rst_n` is 0, which covers the whole reset step. `tx_sel` encodes the pattern as 0 null, 1 PRBS, 2 scrambled null, 3 training sequence, 4 normal traffic. The mapping per step is: reset and clock align 0, descrambler sync 1, non-zero wait 2, training-sequence sync and deskew 3, zero wait 2, active 4.
- R4: Clock align (0x02) moves to 0x04 only when every bit of `rx_clk_ok` is 1. Any other lane pattern keeps it at 0x02.
- R5: Descrambler sync (0x04) moves to 0x08 only when every bit of `rx_dscr_lock` is 1.
- R6: Non-zero wait (0x08) moves to 0x10 when `rx_nonzero` is 1. Training-sequence sync (0x10) moves to 0x20 when `rx_ts1_seen` is 1.
- R7: Deskew (0x20) moves to 0x40 only when `rx_lanes_aligned` is 1 and every bit of `rx_word_lock` is 1.
- R8: Zero wait (0x40) moves to 0x80 only when `rx_null_seen` and `tret_active` are both 1. Active then holds regardless of the receive flags.
- R9: With `tmo_limit` = L and L nonzero, a wait step (0x02 to 0x40) whose exit condition stays false occupies L+1 cycles. The block then returns to 0x01, drives `dev_rst_n` 0, raises `regload_req`, and sets `timeout_err`. `timeout_err` stays 1 until `rst_n` is low. L = 0 disables the timeout.
- R10: `rst_n` low forces, without waiting for a clock, `status` 0x01, `dev_rst_n` 0, `tx_hiz` 1, `regload_req` 0 and `timeout_err` 0.
- R11: `status` changes by at most one step per clock: either to the next code (a left shift by one) or back to 0x01. This holds even when every exit condition is already true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| tmo_limit | input | TMO_W | Wait-step timeout in cycles, 0 disables |
| regload_done | input | 1 | Register load acknowledged |
| rx_clk_ok | input | LANES | Per-lane receive clock aligned |
| rx_dscr_lock | input | LANES | Per-lane descrambler locked |
| rx_word_lock | input | LANES | Per-lane word lock |
| rx_lanes_aligned | input | 1 | Lanes deskewed |
| rx_nonzero | input | 1 | Non-zero data received |
| rx_ts1_seen | input | 1 | Training sequence detected on receive |
| rx_null_seen | input | 1 | Device returned to scrambled null |
| tret_active | input | 1 | Device return-token indication active |
| regload_req | output | 1 | Request to load device registers |
| dev_rst_n | output | 1 | Active-low device reset |
| tx_hiz | output | 1 | Hold transmit lanes in high impedance |
| tx_sel | output | 3 | Transmit pattern select |
| status | output | 8 | One-hot step code |
| timeout_err | output | 1 | Sticky timeout error |

## Verification
Every step transition, and the outputs that go with it, appears one clock edge after the input condition is presented. The bench therefore drives flags on a falling edge and compares on the following falling edge. A timeout is due L+1 cycles after the step is entered, so the bench checks that the step is still held on each of those cycles and returns to reset on the next one. The reset response is asynchronous and is checked a fraction of a cycle after `rst_n` falls. The lane sweeps cover every partial per-lane pattern, and every one must leave the step unchanged.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

  typedef enum logic [7:0] {
    ST_RESET    = 8'h01,
    ST_CLKALIGN = 8'h02,
    ST_DSCR     = 8'h04,
    ST_NZWAIT   = 8'h08,
    ST_TS1      = 8'h10,
    ST_DESKEW   = 8'h20,
    ST_ZWAIT    = 8'h40,
    ST_ACTIVE   = 8'h80
  } lis_state_t;

  typedef enum logic [2:0] {
    TX_NULL    = 3'd0,
    TX_PRBS    = 3'd1,
    TX_SCRNULL = 3'd2,
    TX_TS1     = 3'd3,
    TX_NORMAL  = 3'd4
  } lis_tx_t;

  function automatic lis_tx_t tx_for(input lis_state_t s);
    case (s)
      ST_DSCR:            return TX_PRBS;
      ST_NZWAIT:          return TX_SCRNULL;
      ST_TS1, ST_DESKEW:  return TX_TS1;
      ST_ZWAIT:           return TX_SCRNULL;
      ST_ACTIVE:          return TX_NORMAL;
      default:            return TX_NULL;
    endcase
  endfunction

endpackage

// File: rtl/lis_lane_all.sv
module lis_lane_all #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] flags,
  output logic             all_set
);
  // A lane milestone counts only once every lane reports it.
  assign all_set = &flags;
endmodule

// File: rtl/lis_wait_timer.sv
module lis_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] limit,
  input  logic             in_wait,
  input  logic             moving,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  // Cleared on every step change, so it counts cycles spent in the current step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!in_wait || moving) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign expire = in_wait && (limit != '0) && (cnt == limit);
endmodule

// File: rtl/lis_fsm.sv
module lis_fsm
  import link_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_all,
  input  logic       dscr_all,
  input  logic       wlock_all,
  input  logic       lanes_aligned,
  input  logic       rx_nonzero,
  input  logic       rx_ts1_seen,
  input  logic       rx_null_seen,
  input  logic       tret_active,
  input  logic       regload_done,
  input  logic       expire,
  output lis_state_t state,
  output logic       in_wait,
  output logic       moving,
  output logic       regload_req,
  output logic       dev_rst_n,
  output logic       timeout_err,
  output lis_tx_t    tx_sel
);
  lis_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:    if (regload_req && regload_done) nxt = ST_CLKALIGN;
      ST_CLKALIGN: if (clk_all) nxt = ST_DSCR;
                   else if (expire) nxt = ST_RESET;
      ST_DSCR:     if (dscr_all) nxt = ST_NZWAIT;
                   else if (expire) nxt = ST_RESET;
      ST_NZWAIT:   if (rx_nonzero) nxt = ST_TS1;
                   else if (expire) nxt = ST_RESET;
      ST_TS1:      if (rx_ts1_seen) nxt = ST_DESKEW;
                   else if (expire) nxt = ST_RESET;
      ST_DESKEW:   if (lanes_aligned && wlock_all) nxt = ST_ZWAIT;
                   else if (expire) nxt = ST_RESET;
      ST_ZWAIT:    if (rx_null_seen && tret_active) nxt = ST_ACTIVE;
                   else if (expire) nxt = ST_RESET;
      ST_ACTIVE:   nxt = ST_ACTIVE;
      default:     nxt = ST_RESET;
    endcase
  end

  assign in_wait = (state != ST_RESET) && (state != ST_ACTIVE);
  assign moving  = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RESET;
      regload_req <= 1'b0;
      dev_rst_n   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      state       <= nxt;
      regload_req <= (nxt == ST_RESET);
      dev_rst_n   <= (nxt != ST_RESET);
      if (in_wait && nxt == ST_RESET) timeout_err <= 1'b1;
    end
  end

  assign tx_sel = tx_for(state);
endmodule

// File: rtl/link_init_seq.sv
module link_init_seq
  import link_init_pkg::*;
#(
  parameter int LANES = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             regload_done,
  input  logic [LANES-1:0] rx_clk_ok,
  input  logic [LANES-1:0] rx_dscr_lock,
  input  logic [LANES-1:0] rx_word_lock,
  input  logic             rx_lanes_aligned,
  input  logic             rx_nonzero,
  input  logic             rx_ts1_seen,
  input  logic             rx_null_seen,
  input  logic             tret_active,
  output logic             regload_req,
  output logic             dev_rst_n,
  output logic             tx_hiz,
  output logic [2:0]       tx_sel,
  output logic [7:0]       status,
  output logic             timeout_err
);
  logic       clk_all, dscr_all, wlock_all;
  logic       in_wait, moving, expire;
  lis_state_t state;
  lis_tx_t    tx_code;

  lis_lane_all #(.LANES(LANES)) u_clk_all  (.flags(rx_clk_ok),    .all_set(clk_all));
  lis_lane_all #(.LANES(LANES)) u_dscr_all (.flags(rx_dscr_lock), .all_set(dscr_all));
  lis_lane_all #(.LANES(LANES)) u_wl_all   (.flags(rx_word_lock), .all_set(wlock_all));

  lis_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .limit(tmo_limit),
    .in_wait(in_wait), .moving(moving), .expire(expire)
  );

  lis_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .clk_all(clk_all), .dscr_all(dscr_all), .wlock_all(wlock_all),
    .lanes_aligned(rx_lanes_aligned), .rx_nonzero(rx_nonzero),
    .rx_ts1_seen(rx_ts1_seen), .rx_null_seen(rx_null_seen),
    .tret_active(tret_active), .regload_done(regload_done),
    .expire(expire), .state(state), .in_wait(in_wait), .moving(moving),
    .regload_req(regload_req), .dev_rst_n(dev_rst_n),
    .timeout_err(timeout_err), .tx_sel(tx_code)
  );

  assign status = state;
  assign tx_sel = tx_code;
  assign tx_hiz = ~dev_rst_n;
endmodule

// File: rtl/link_init_seq_chk.sv
module link_init_seq_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] rx_dscr_lock,
  input logic [LANES-1:0] rx_word_lock,
  input logic             rx_lanes_aligned,
  input logic             rx_null_seen,
  input logic             tret_active,
  input logic             regload_req,
  input logic             regload_done,
  input logic             dev_rst_n,
  input logic             tx_hiz,
  input logic             timeout_err,
  input logic [7:0]       status
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);

  a_r2_release_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> $past(regload_req && regload_done));

  a_r3_hiz_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h01) |-> (tx_hiz && !dev_rst_n));

  a_r5_dscr_all: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h08 && $past(status) == 8'h04) |-> $past(&rx_dscr_lock));

  a_r7_deskew_all: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h40 && $past(status) == 8'h20)
      |-> $past(rx_lanes_aligned && (&rx_word_lock)));

  a_r8_active_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h80 && $past(status) == 8'h40) |-> $past(rx_null_seen && tret_active));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |-> (status == 8'h01 || status == ($past(status) << 1)));
endmodule

bind link_init_seq link_init_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_dscr_lock(rx_dscr_lock), .rx_word_lock(rx_word_lock),
  .rx_lanes_aligned(rx_lanes_aligned), .rx_null_seen(rx_null_seen),
  .tret_active(tret_active), .regload_req(regload_req),
  .regload_done(regload_done), .dev_rst_n(dev_rst_n), .tx_hiz(tx_hiz),
  .timeout_err(timeout_err), .status(status)
);

// File: tb/link_init_seq_test.sv
`timescale 1ns/1ps
module link_init_seq_test;
  localparam int L = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tmo_limit = '0;
  logic          regload_done = 1'b0;
  logic [L-1:0]  rx_clk_ok = '0, rx_dscr_lock = '0, rx_word_lock = '0;
  logic          rx_lanes_aligned = 1'b0, rx_nonzero = 1'b0, rx_ts1_seen = 1'b0;
  logic          rx_null_seen = 1'b0, tret_active = 1'b0;
  logic          regload_req, dev_rst_n, tx_hiz, timeout_err;
  logic [2:0]    tx_sel;
  logic [7:0]    status;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  link_init_seq #(.LANES(L), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .regload_done(regload_done),
    .rx_clk_ok(rx_clk_ok), .rx_dscr_lock(rx_dscr_lock), .rx_word_lock(rx_word_lock),
    .rx_lanes_aligned(rx_lanes_aligned), .rx_nonzero(rx_nonzero),
    .rx_ts1_seen(rx_ts1_seen), .rx_null_seen(rx_null_seen), .tret_active(tret_active),
    .regload_req(regload_req), .dev_rst_n(dev_rst_n), .tx_hiz(tx_hiz),
    .tx_sel(tx_sel), .status(status), .timeout_err(timeout_err)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected pattern per step (R3): 0 null,1 PRBS,2 scrambled null,3 TS,4 normal.
  function automatic logic [2:0] exp_tx(input logic [7:0] st);
    case (st)
      8'h04: return 3'd1;
      8'h08, 8'h40: return 3'd2;
      8'h10, 8'h20: return 3'd3;
      8'h80: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk_st(input string rq, input logic [7:0] st);
    chk(rq, "status", status, st);
    chk(rq, "tx_sel", tx_sel, exp_tx(st));
    chk(rq, "tx_hiz", tx_hiz, st == 8'h01);
  endtask

  task automatic clear_flags();
    rx_clk_ok = '0; rx_dscr_lock = '0; rx_word_lock = '0;
    rx_lanes_aligned = 0; rx_nonzero = 0; rx_ts1_seen = 0;
    rx_null_seen = 0; tret_active = 0;
  endtask

  // Reset, then handshake with done held high: reaches 0x02 two edges later.
  task automatic restart_to_clkalign();
    @(negedge clk); rst_n = 0; regload_done = 1;
    #1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    regload_done = 0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R10 reset state; done held high to prove it is ignored before request (R2)
    regload_done = 1;
    repeat (3) @(negedge clk);
    chk_st("R10", 8'h01);
    chk("R10", "regload_req", regload_req, 0);
    chk("R10", "dev_rst_n", dev_rst_n, 0);
    chk("R10", "timeout_err", timeout_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk_st("R2", 8'h01);
    chk("R2", "regload_req", regload_req, 1);
    chk("R2", "dev_rst_n", dev_rst_n, 0);
    @(negedge clk);
    chk_st("R2", 8'h02);
    chk("R2", "regload_req", regload_req, 0);
    chk("R2", "dev_rst_n", dev_rst_n, 1);
    regload_done = 0;

    // R4 sweep every partial clock-align pattern
    for (int p = 0; p < (1 << L) - 1; p++) begin
      rx_clk_ok = p[L-1:0];
      @(negedge clk);
      chk_st("R4", 8'h02);
    end
    rx_clk_ok = '1;
    @(negedge clk);
    chk_st("R4", 8'h04);
    rx_clk_ok = '0;

    // R5 descrambler sweep
    for (int p = 0; p < (1 << L) - 1; p++) begin
      rx_dscr_lock = p[L-1:0];
      @(negedge clk);
      chk_st("R5", 8'h04);
    end
    rx_dscr_lock = '1;
    @(negedge clk);
    chk_st("R5", 8'h08);
    rx_dscr_lock = '0;

    // R6 non-zero wait then training-sequence sync
    repeat (3) begin @(negedge clk); chk_st("R6", 8'h08); end
    rx_ts1_seen = 1;
    @(negedge clk);
    chk_st("R6", 8'h08);
    rx_ts1_seen = 0; rx_nonzero = 1;
    @(negedge clk);
    chk_st("R6", 8'h10);
    rx_nonzero = 0;
    @(negedge clk);
    chk_st("R6", 8'h10);
    rx_ts1_seen = 1;
    @(negedge clk);
    chk_st("R6", 8'h20);
    rx_ts1_seen = 0;

    // R7 deskew: every combination of aligned and word lock except all set
    for (int p = 0; p < (2 << L) - 1; p++) begin
      rx_word_lock = p[L-1:0];
      rx_lanes_aligned = p[L];
      @(negedge clk);
      chk_st("R7", 8'h20);
    end
    rx_word_lock = '1; rx_lanes_aligned = 1;
    @(negedge clk);
    chk_st("R7", 8'h40);
    clear_flags();

    // R8 zero wait needs null seen and return token together
    for (int p = 0; p < 3; p++) begin
      rx_null_seen = p[0]; tret_active = p[1];
      @(negedge clk);
      chk_st("R8", 8'h40);
    end
    rx_null_seen = 1; tret_active = 1;
    @(negedge clk);
    chk_st("R8", 8'h80);
    clear_flags();
    repeat (4) begin @(negedge clk); chk_st("R8", 8'h80); end
    chk("R8", "dev_rst_n", dev_rst_n, 1);

    // R10 asynchronous reset from active
    #1 rst_n = 0;
    #0.5;
    chk_st("R10", 8'h01);
    chk("R10", "dev_rst_n", dev_rst_n, 0);
    chk("R10", "regload_req", regload_req, 0);

    // R11 all conditions true: one step per clock
    rx_clk_ok = '1; rx_dscr_lock = '1; rx_word_lock = '1; rx_lanes_aligned = 1;
    rx_nonzero = 1; rx_ts1_seen = 1; rx_null_seen = 1; tret_active = 1;
    regload_done = 1;
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk_st("R11", 8'h01);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk_st("R11", 8'h01 << k);
      chk("R1", "onehot", $countones(status), 1);
    end
    clear_flags();
    regload_done = 0;

    // R9 timeout in clock align for several limits
    for (int lim = 1; lim <= 5; lim++) begin
      tmo_limit = lim[TW-1:0];
      restart_to_clkalign();
      for (int k = 0; k <= lim; k++) begin
        chk_st("R9", 8'h02);
        chk("R9", "timeout_err", timeout_err, 0);
        @(negedge clk);
      end
      chk_st("R9", 8'h01);
      chk("R9", "timeout_err", timeout_err, 1);
      chk("R9", "regload_req", regload_req, 1);
      chk("R9", "dev_rst_n", dev_rst_n, 0);
    end

    // R9 timer restarts per step: timeout in descrambler sync after lim+1 cycles there
    tmo_limit = 3;
    restart_to_clkalign();
    rx_clk_ok = '1;
    @(negedge clk);
    rx_clk_ok = '0;
    for (int k = 0; k <= 3; k++) begin
      chk_st("R9", 8'h04);
      @(negedge clk);
    end
    chk_st("R9", 8'h01);
    chk("R9", "timeout_err", timeout_err, 1);
    // sticky through a new handshake
    regload_done = 1;
    @(negedge clk);
    regload_done = 0;
    chk_st("R9", 8'h02);
    chk("R9", "sticky timeout_err", timeout_err, 1);

    // R9 limit zero disables the timeout
    tmo_limit = 0;
    restart_to_clkalign();
    repeat (40) @(negedge clk);
    chk_st("R9", 8'h02);
    chk("R9", "timeout_err", timeout_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule